// File: doc/BRIEF.md
# Two-Queue Radio Slot Arbiter

This block chooses which pending radio event starts in each scheduling slot, for a radio that is time-shared between a BLE stack and a Thread stack. Each protocol has its own small first-in first-out queue of events. An event is one packed word that holds an absolute start time in slots, a class, a critical flag, a PHY mode, a channel number and a 2-bit key slot. A 32-bit slot counter advances once on every slot strobe. The strobe normally comes from a timer with a 625 µs period.

On each strobe the block looks at the head of each queue, using the counter value from before the strobe. A head can launch only when its time has arrived. If both heads can launch, the earlier timestamp wins. When the timestamps are equal, the tie is settled in this order: the critical flag first, then a class ranking in which Thread wins equal ranks, and finally a round-robin pointer when both events are critical. The winning event appears on the launch port for one cycle and is removed from its queue. The other queue is left as it was.

Each enqueue port is a valid/ready stream. A word is accepted on a rising clock edge only when valid and ready are both high. Ready is low exactly when the queue already holds four entries. While ready is low, the producer must keep its word and valid stable. An offer made while the queue is full is not stored. A pop by the arbiter frees space only from the following cycle on. The launch output has no back-pressure: the consumer must take the pulse in the cycle it appears.

Top module: `radio_slot_arbiter`

## Requirements
- R1: After reset `tick_o` is 0. It increments by exactly one on each clock edge where `slot_i` is high, and it holds its value otherwise.
- R2: A queue head is eligible only when its timestamp is at most the pre-strobe tick value, compared as unsigned numbers. A strobe with no eligible head produces no launch pulse.
- R3: When both heads are eligible and their timestamps differ, the head with the smaller timestamp is launched.
- R4: On a timestamp tie where neither event is critical, the higher class rank wins. The class encodings are 3 = Thread beacon, 2 = BLE connection, 1 = Thread data, 0 = BLE advertising. On equal rank the Thread event wins.
- R5: On a timestamp tie where exactly one event is critical, the critical event wins, whatever the classes are.
- R6: On a timestamp tie where both events are critical, the first such tie after reset goes to Thread, and later such ties alternate between the queues. The pointer changes only on critical-versus-critical ties.
- R7: `launch_valid_o` is high for the one cycle after the strobe edge. During that cycle `launch_evt_o` carries the winning word unchanged and `launch_thread_o` is 1 if the word came from the Thread queue. The winner is removed from its queue, and the other queue is left as it was.
- R8: Each queue holds 4 entries and pops in arrival order. Ready is low while the queue is full, and a word offered while full is not stored. The event word is laid out as {timestamp[44:13], class[12:11], critical[10], phy[9:8], channel[7:2], key[1:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Slot strobe; one evaluation per high cycle |
| ble_valid_i | input | 1 | BLE enqueue valid |
| ble_ready_o | output | 1 | BLE queue can accept a word |
| ble_evt_i | input | 45 | BLE event word |
| thr_valid_i | input | 1 | Thread enqueue valid |
| thr_ready_o | output | 1 | Thread queue can accept a word |
| thr_evt_i | input | 45 | Thread event word |
| tick_o | output | 32 | Current slot count |
| launch_valid_o | output | 1 | One-cycle launch pulse |
| launch_thread_o | output | 1 | Launched event came from the Thread queue |
| launch_evt_o | output | 45 | Launched event word |

## Verification
A push and a pop can hit the same queue on the same clock edge: the strobe removes the head while the producer hands over a new word. The bench provokes this by raising the strobe and BLE valid in the same cycle while the BLE queue holds exactly one eligible entry. It then checks that the old head launches immediately and that the new word launches on the next strobe, with none lost or duplicated. A second overlap is a timestamp tie where both events are critical, which both launches an event and moves the round-robin pointer. This is judged over three such ties, separated by solo launches that must not move the pointer.

// File: rtl/radio_arb_pkg.sv
package radio_arb_pkg;
  localparam int TS_W   = 32;
  localparam int CLS_W  = 2;
  localparam int PHY_W  = 2;
  localparam int CHAN_W = 6;
  localparam int KEY_W  = 2;
  localparam int EVT_W  = TS_W + CLS_W + 1 + PHY_W + CHAN_W + KEY_W;

  // class rank: larger value outranks smaller on a timestamp tie
  typedef enum logic [CLS_W-1:0] {
    CLS_BLE_ADV    = 2'd0,
    CLS_THR_DATA   = 2'd1,
    CLS_BLE_CONN   = 2'd2,
    CLS_THR_BEACON = 2'd3
  } evt_cls_e;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [CLS_W-1:0]  cls;
    logic              crit;
    logic [PHY_W-1:0]  phy;
    logic [CHAN_W-1:0] chan;
    logic [KEY_W-1:0]  key;
  } radio_evt_t;
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo
  import radio_arb_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  output logic       push_ready,
  input  radio_evt_t push_data,
  input  logic       pop,
  output logic       head_valid,
  output radio_evt_t head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  radio_evt_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign push_ready = (count != FULLC);
  assign head_valid = (count != '0);
  assign head       = mem[rd_ptr];
  assign do_push    = push_valid && push_ready;
  assign do_pop     = pop && head_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_ready && !pop) |=> (count == $past(count)));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
endmodule

// File: rtl/slot_tick.sv
module slot_tick
  import radio_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot,
  output logic [TS_W-1:0] tick
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick <= '0;
    else if (slot) tick <= tick + 1'b1;
  end

  assert_tick_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slot |=> (tick == $past(tick) + 1'b1));
  assert_tick_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !slot |=> $stable(tick));
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import radio_arb_pkg::*;
(
  input  logic             b_vld,
  input  logic [TS_W-1:0]  b_ts,
  input  logic [CLS_W-1:0] b_cls,
  input  logic             b_crit,
  input  logic             t_vld,
  input  logic [TS_W-1:0]  t_ts,
  input  logic [CLS_W-1:0] t_cls,
  input  logic             t_crit,
  input  logic [TS_W-1:0]  now,
  input  logic             rr_ble,
  output logic             go,
  output logic             pick_thr,
  output logic             rr_used
);
  logic b_el, t_el;
  assign b_el = b_vld && (b_ts <= now);
  assign t_el = t_vld && (t_ts <= now);

  always_comb begin
    go       = b_el || t_el;
    pick_thr = 1'b0;
    rr_used  = 1'b0;
    if (b_el && t_el) begin
      if (t_ts < b_ts)            pick_thr = 1'b1;
      else if (b_ts < t_ts)       pick_thr = 1'b0;
      else if (b_crit && t_crit) begin
        pick_thr = !rr_ble;
        rr_used  = 1'b1;
      end
      else if (b_crit != t_crit)  pick_thr = t_crit;
      else                        pick_thr = (t_cls >= b_cls);
    end else begin
      pick_thr = t_el;
    end
  end

  assert_pick_eligible_R2: assert final (!go || (pick_thr ? t_el : b_el));
endmodule

// File: rtl/radio_slot_arbiter.sv
module radio_slot_arbiter
  import radio_arb_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_i,
  input  logic             ble_valid_i,
  output logic             ble_ready_o,
  input  logic [EVT_W-1:0] ble_evt_i,
  input  logic             thr_valid_i,
  output logic             thr_ready_o,
  input  logic [EVT_W-1:0] thr_evt_i,
  output logic [TS_W-1:0]  tick_o,
  output logic             launch_valid_o,
  output logic             launch_thread_o,
  output logic [EVT_W-1:0] launch_evt_o
);
  radio_evt_t b_head, t_head;
  logic       b_hv, t_hv;
  logic       go, pick_thr, rr_used;
  logic       rr_ble_q;
  logic       fire;
  radio_evt_t launch_q;

  assign fire = slot_i && go;

  evt_fifo #(.DEPTH(QDEPTH)) u_ble_q (
    .clk(clk), .rst_n(rst_n),
    .push_valid(ble_valid_i), .push_ready(ble_ready_o),
    .push_data(radio_evt_t'(ble_evt_i)),
    .pop(fire && !pick_thr),
    .head_valid(b_hv), .head(b_head));

  evt_fifo #(.DEPTH(QDEPTH)) u_thr_q (
    .clk(clk), .rst_n(rst_n),
    .push_valid(thr_valid_i), .push_ready(thr_ready_o),
    .push_data(radio_evt_t'(thr_evt_i)),
    .pop(fire && pick_thr),
    .head_valid(t_hv), .head(t_head));

  slot_tick u_tick (.clk(clk), .rst_n(rst_n), .slot(slot_i), .tick(tick_o));

  arb_pick u_pick (
    .b_vld(b_hv), .b_ts(b_head.ts), .b_cls(b_head.cls), .b_crit(b_head.crit),
    .t_vld(t_hv), .t_ts(t_head.ts), .t_cls(t_head.cls), .t_crit(t_head.crit),
    .now(tick_o), .rr_ble(rr_ble_q),
    .go(go), .pick_thr(pick_thr), .rr_used(rr_used));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ble_q        <= 1'b0;
      launch_valid_o  <= 1'b0;
      launch_thread_o <= 1'b0;
      launch_q        <= '0;
    end else begin
      launch_valid_o <= fire;
      if (fire) begin
        launch_thread_o <= pick_thr;
        launch_q        <= pick_thr ? t_head : b_head;
      end
      if (fire && rr_used) rr_ble_q <= !rr_ble_q;
    end
  end

  assign launch_evt_o = launch_q;

  assert_launch_after_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid_o |-> $past(slot_i));
  assert_launch_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid_o |-> (launch_q.ts < tick_o));
  assert_rr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && rr_used) |=> $stable(rr_ble_q));
  assert_rr_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rr_used) |=> (rr_ble_q != $past(rr_ble_q)));
endmodule

// File: tb/radio_slot_arbiter_bench.sv
module radio_slot_arbiter_bench;
  localparam int EW = 45;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_i = 1'b0;
  logic          ble_valid_i = 1'b0, thr_valid_i = 1'b0;
  logic [EW-1:0] ble_evt_i = '0, thr_evt_i = '0;
  logic          ble_ready_o, thr_ready_o;
  logic [31:0]   tick_o;
  logic          launch_valid_o, launch_thread_o;
  logic [EW-1:0] launch_evt_o;

  int errors = 0;
  int checks = 0;
  int exp_tick = 0;

  always #10 clk = ~clk;

  radio_slot_arbiter u_radio_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i),
    .ble_valid_i(ble_valid_i), .ble_ready_o(ble_ready_o), .ble_evt_i(ble_evt_i),
    .thr_valid_i(thr_valid_i), .thr_ready_o(thr_ready_o), .thr_evt_i(thr_evt_i),
    .tick_o(tick_o), .launch_valid_o(launch_valid_o),
    .launch_thread_o(launch_thread_o), .launch_evt_o(launch_evt_o));

  function automatic logic [EW-1:0] mk(int ts, int cls, bit crit, int tag);
    return {ts[31:0], cls[1:0], crit, tag[9:0]};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(bit thr, logic [EW-1:0] w);
    @(negedge clk);
    if (thr) begin thr_valid_i = 1'b1; thr_evt_i = w; end
    else     begin ble_valid_i = 1'b1; ble_evt_i = w; end
    @(negedge clk);
    thr_valid_i = 1'b0; ble_valid_i = 1'b0;
  endtask

  // one strobe; returns launch outputs seen in the cycle after the edge
  task automatic strobe(output bit v, output bit thr, output logic [EW-1:0] w);
    @(negedge clk);
    slot_i = 1'b1;
    @(negedge clk);
    slot_i = 1'b0;
    exp_tick++;
    v = launch_valid_o; thr = launch_thread_o; w = launch_evt_o;
  endtask

  task automatic expect_launch(string req, bit thr, logic [EW-1:0] w);
    bit v, t; logic [EW-1:0] got;
    strobe(v, t, got);
    check(req, {63'd0, v}, 64'd1);
    check(req, {63'd0, t}, {63'd0, thr});
    check(req, {19'd0, got}, {19'd0, w});
  endtask

  task automatic expect_none(string req);
    bit v, t; logic [EW-1:0] got;
    strobe(v, t, got);
    check(req, {63'd0, v}, 64'd0);
  endtask

  task automatic t_reset;
    check("R1 reset tick", {32'd0, tick_o}, 64'd0);
    check("R7 reset launch", {63'd0, launch_valid_o}, 64'd0);
    check("R8 reset ready", {62'd0, ble_ready_o, thr_ready_o}, 64'd3);
  endtask

  task automatic t_tick;
    expect_none("R2 empty queues");
    expect_none("R2 empty queues");
    @(negedge clk); @(negedge clk);
    check("R1 tick count", {32'd0, tick_o}, 64'(exp_tick));
  endtask

  task automatic t_not_due;
    logic [EW-1:0] e = mk(exp_tick + 1, 0, 0, 11);
    push(0, e);
    expect_none("R2 not yet due");
    expect_launch("R2 due launch", 0, e);
  endtask

  task automatic t_earlier;
    logic [EW-1:0] b = mk(exp_tick - 1, 0, 0, 21);
    logic [EW-1:0] t = mk(exp_tick, 3, 1, 22);
    push(0, b); push(1, t);
    expect_launch("R3 earlier ble", 0, b);
    expect_launch("R7 other kept", 1, t);
    b = mk(exp_tick, 3, 1, 23);
    t = mk(exp_tick - 1, 0, 0, 24);
    push(0, b); push(1, t);
    expect_launch("R3 earlier thread", 1, t);
    expect_launch("R7 other kept", 0, b);
  endtask

  task automatic t_class;
    logic [EW-1:0] b = mk(exp_tick, 2, 0, 31);
    logic [EW-1:0] t = mk(exp_tick, 1, 0, 32);
    push(0, b); push(1, t);
    expect_launch("R4 conn over data", 0, b);
    expect_launch("R4 drain", 1, t);
    b = mk(exp_tick, 0, 0, 33); t = mk(exp_tick, 1, 0, 34);
    push(0, b); push(1, t);
    expect_launch("R4 data over adv", 1, t);
    expect_launch("R4 drain", 0, b);
    b = mk(exp_tick, 2, 0, 35); t = mk(exp_tick, 2, 0, 36);
    push(0, b); push(1, t);
    expect_launch("R4 equal rank thread", 1, t);
    expect_launch("R4 drain", 0, b);
  endtask

  task automatic t_crit;
    logic [EW-1:0] b = mk(exp_tick, 0, 1, 41);
    logic [EW-1:0] t = mk(exp_tick, 3, 0, 42);
    push(0, b); push(1, t);
    expect_launch("R5 critical ble", 0, b);
    expect_launch("R5 drain", 1, t);
    b = mk(exp_tick, 2, 0, 43); t = mk(exp_tick, 0, 1, 44);
    push(0, b); push(1, t);
    expect_launch("R5 critical thread", 1, t);
    expect_launch("R5 drain", 0, b);
  endtask

  task automatic t_rr;
    for (int i = 0; i < 3; i++) begin
      logic [EW-1:0] b = mk(exp_tick, 1, 1, 50 + 2 * i);
      logic [EW-1:0] t = mk(exp_tick, 1, 1, 51 + 2 * i);
      bit thr_first = (i != 1);
      push(0, b); push(1, t);
      expect_launch("R6 rr tie", thr_first, thr_first ? t : b);
      expect_launch("R6 solo", !thr_first, thr_first ? b : t);
    end
  endtask

  task automatic t_full;
    logic [EW-1:0] w [4];
    for (int i = 0; i < 4; i++) begin
      w[i] = mk(exp_tick, 0, 0, 60 + i);
      push(0, w[i]);
    end
    check("R8 ready low when full", {63'd0, ble_ready_o}, 64'd0);
    push(0, mk(exp_tick, 3, 1, 99));
    for (int i = 0; i < 4; i++) expect_launch("R8 fifo order", 0, w[i]);
    expect_none("R8 full offer dropped");
    check("R8 ready back", {63'd0, ble_ready_o}, 64'd1);
  endtask

  task automatic t_same_cycle;
    logic [EW-1:0] a = mk(exp_tick, 0, 0, 71);
    logic [EW-1:0] n = mk(exp_tick, 0, 0, 72);
    bit v, t; logic [EW-1:0] got;
    push(0, a);
    @(negedge clk);
    slot_i = 1'b1; ble_valid_i = 1'b1; ble_evt_i = n;
    @(negedge clk);
    slot_i = 1'b0; ble_valid_i = 1'b0;
    exp_tick++;
    v = launch_valid_o; t = launch_thread_o; got = launch_evt_o;
    check("R7 pop with push", {63'd0, v}, 64'd1);
    check("R7 pop with push", {19'd0, got}, {19'd0, a});
    expect_launch("R8 pushed kept", 0, n);
    expect_none("R8 no duplicate");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_not_due();
    t_earlier();
    t_class();
    t_crit();
    t_rr();
    t_full();
    t_same_cycle();
    check("R1 final tick", {32'd0, tick_o}, 64'(exp_tick));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule